// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control core of a single DMA channel. Software arms the channel with a word total, a chunk size and a chain flag. The channel then counts words, one per clock at most, while a peripheral holds its request line high. It pulses an acknowledge back to the peripheral each time a full chunk has moved. The peripheral may cut the transfer short through an end-of-descriptor line. That line is honoured only at the very start of a transfer and at chunk boundaries.

A transfer ends in one of four ways: the programmed total is reached, the peripheral ends it, it is skipped at start, or software aborts it. When the chain flag is set, the channel takes a fresh total, chunk size and chain flag from a descriptor port and keeps running. Otherwise it drops its enable and waits to be armed again. Status flags (enable, busy, done, error) and a one-cycle interrupt pulse are visible at the ports. The data mover and the address logic are outside this block.

Top module: `dma_chan_ctrl`

## Requirements
- R1: While the enable flag is clear, no word is taken (`word_xfer` stays 0) and `word_count` does not change, whatever `per_req` does.
- R2: A stop request, given while enabled, takes effect on the next clock. Enable and busy are cleared and error is set. `irq` pulses for one cycle only when `cfg_err_irq_en` is 1.
- R3: On the first clock after arming, the channel clears done and error, sets busy and zeroes `word_count`.
- R4: If `per_nd` is high on that first clock, the descriptor is skipped: no word moves, done is set, enable is cleared and no interrupt is raised.
- R5: `per_ack` is high for the cycle after each word that brings the count within the current descriptor to a multiple of the chunk size. It is never high without a word in the preceding cycle.
- R6: A high `per_nd` on a word that completes a chunk ends the transfer with done set and no interrupt. A high `per_nd` on any other word is ignored.
- R7: When a transfer ends with the chain flag set, `desc_load` pulses for one cycle and the next descriptor's values are taken. Busy and enable stay set and `word_count` restarts at 0.
- R8: When the word count reaches the programmed total, busy clears, done sets, and `irq` pulses only when `cfg_done_irq_en` is 1.
- R9: In a cycle where a pending stop is acted on, no word is taken, even with `per_req` high.
- R10: At most one word is taken per clock, and only in a cycle with `per_req` high.
- R11: Every termination without the chain flag clears enable, so the channel does nothing until armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_arm | input | 1 | Arm pulse; latches the cfg_* transfer values while disabled |
| sw_stop | input | 1 | Abort request pulse |
| cfg_err_irq_en | input | 1 | Interrupt on abort |
| cfg_done_irq_en | input | 1 | Interrupt on normal completion |
| cfg_linked | input | 1 | Chain flag for the first descriptor |
| cfg_total | input | CNT_W | Word total of the first descriptor |
| cfg_chunk | input | CNT_W | Chunk size of the first descriptor |
| per_req | input | 1 | Peripheral request, one word per high cycle |
| per_nd | input | 1 | Peripheral end-of-descriptor |
| per_ack | output | 1 | Chunk complete pulse |
| nxt_total | input | CNT_W | Word total of the next descriptor |
| nxt_chunk | input | CNT_W | Chunk size of the next descriptor |
| nxt_linked | input | 1 | Chain flag of the next descriptor |
| desc_load | output | 1 | Pulse: next descriptor was taken |
| word_xfer | output | 1 | A word is taken this cycle |
| word_count | output | CNT_W | Words moved in the current descriptor |
| st_enable | output | 1 | Enable flag |
| st_busy | output | 1 | Busy flag |
| st_done | output | 1 | Done flag |
| st_error | output | 1 | Error flag |
| irq | output | 1 | Interrupt pulse |

## Verification
Two functions can meet in one cycle. The first pair is a pending stop and a peripheral request. The bench raises the stop together with a request and keeps the request high. It expects the word from the stop cycle to be counted, and no word in the abort cycle, so the count is judged to be exactly one higher than before. The second pair is a chunk boundary and a chained reload on the same word. There the scoreboard expects the acknowledge while `word_count` already reads zero, and `desc_load` must follow.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    TERM_NONE,
    TERM_SKIP,
    TERM_PEER,
    TERM_COUNT
  } term_e;

  // only a count-complete end may raise the completion interrupt
  function automatic logic term_irq(input term_e cause, input logic done_en);
    return (cause == TERM_COUNT) && done_en;
  endfunction

endpackage

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] chunk_size,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] word_cnt,
  output logic             chunk_hit,
  output logic             last_hit
);

  logic [CNT_W-1:0] chunk_cnt;
  logic [CNT_W-1:0] word_nxt;
  logic [CNT_W-1:0] chunk_nxt;

  // a limit of zero never matches
  function automatic logic reaches(input logic [CNT_W-1:0] nxt,
                                   input logic [CNT_W-1:0] lim);
    return (lim != '0) && (nxt == lim);
  endfunction

  always_comb begin
    word_nxt  = word_cnt + 1'b1;
    chunk_nxt = chunk_cnt + 1'b1;
    chunk_hit = step && reaches(chunk_nxt, chunk_size);
    last_hit  = step && reaches(word_nxt, total);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_cnt  <= '0;
      chunk_cnt <= '0;
    end else if (clr) begin
      word_cnt  <= '0;
      chunk_cnt <= '0;
    end else if (step) begin
      word_cnt  <= word_nxt;
      chunk_cnt <= chunk_hit ? '0 : chunk_nxt;
    end
  end

endmodule

// File: rtl/dma_desc_hold.sv
module dma_desc_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_sw,
  input  logic [CNT_W-1:0] sw_total,
  input  logic [CNT_W-1:0] sw_chunk,
  input  logic             sw_linked,
  input  logic             load_next,
  input  logic [CNT_W-1:0] nx_total,
  input  logic [CNT_W-1:0] nx_chunk,
  input  logic             nx_linked,
  output logic [CNT_W-1:0] cur_total,
  output logic [CNT_W-1:0] cur_chunk,
  output logic             cur_linked
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_total  <= '0;
      cur_chunk  <= '0;
      cur_linked <= 1'b0;
    end else if (load_sw) begin
      cur_total  <= sw_total;
      cur_chunk  <= sw_chunk;
      cur_linked <= sw_linked;
    end else if (load_next) begin
      cur_total  <= nx_total;
      cur_chunk  <= nx_chunk;
      cur_linked <= nx_linked;
    end
  end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_arm,
  input  logic sw_stop,
  input  logic err_irq_en,
  input  logic done_irq_en,
  input  logic per_req,
  input  logic per_nd,
  input  logic chunk_hit,
  input  logic last_hit,
  input  logic cur_linked,
  output logic en_q,
  output logic busy_q,
  output logic done_q,
  output logic err_q,
  output logic irq_q,
  output logic ack_q,
  output logic load_q,
  output logic word_xfer,
  output logic arm_evt,
  output logic abort_evt,
  output logic start_evt,
  output logic reload_evt,
  output logic cnt_clr
);

  logic  stop_q;
  logic  finish_evt;
  term_e cause;

  always_comb begin
    arm_evt   = !en_q && sw_arm;
    abort_evt = en_q && stop_q;
    start_evt = en_q && !stop_q && !busy_q;
    word_xfer = en_q && !stop_q && busy_q && per_req;

    if (start_evt && per_nd)                      cause = TERM_SKIP;
    else if (word_xfer && chunk_hit && per_nd)    cause = TERM_PEER;
    else if (word_xfer && last_hit)               cause = TERM_COUNT;
    else                                          cause = TERM_NONE;

    reload_evt = (cause != TERM_NONE) && cur_linked;
    finish_evt = (cause != TERM_NONE) && !cur_linked;
    cnt_clr    = start_evt || reload_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stop_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      ack_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      if (arm_evt)                      en_q <= 1'b1;
      else if (abort_evt || finish_evt) en_q <= 1'b0;

      if (abort_evt || finish_evt)      stop_q <= 1'b0;
      else if (en_q && sw_stop)         stop_q <= 1'b1;

      if (abort_evt || finish_evt)      busy_q <= 1'b0;
      else if (start_evt)               busy_q <= 1'b1;

      if (finish_evt)                   done_q <= 1'b1;
      else if (start_evt)               done_q <= 1'b0;

      if (abort_evt)                    err_q <= 1'b1;
      else if (start_evt)               err_q <= 1'b0;

      irq_q  <= (abort_evt && err_irq_en) ||
                (finish_evt && term_irq(cause, done_irq_en));
      ack_q  <= word_xfer && chunk_hit;
      load_q <= reload_evt;
    end
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_arm,
  input  logic             sw_stop,
  input  logic             cfg_err_irq_en,
  input  logic             cfg_done_irq_en,
  input  logic             cfg_linked,
  input  logic [CNT_W-1:0] cfg_total,
  input  logic [CNT_W-1:0] cfg_chunk,
  input  logic             per_req,
  input  logic             per_nd,
  output logic             per_ack,
  input  logic [CNT_W-1:0] nxt_total,
  input  logic [CNT_W-1:0] nxt_chunk,
  input  logic             nxt_linked,
  output logic             desc_load,
  output logic             word_xfer,
  output logic [CNT_W-1:0] word_count,
  output logic             st_enable,
  output logic             st_busy,
  output logic             st_done,
  output logic             st_error,
  output logic             irq
);

  logic [CNT_W-1:0] cur_total;
  logic [CNT_W-1:0] cur_chunk;
  logic             cur_linked;
  logic             chunk_hit;
  logic             last_hit;
  logic             arm_evt;
  logic             abort_evt;
  logic             start_evt;
  logic             reload_evt;
  logic             cnt_clr;

  dma_desc_hold #(.CNT_W(CNT_W)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_sw    (arm_evt),
    .sw_total   (cfg_total),
    .sw_chunk   (cfg_chunk),
    .sw_linked  (cfg_linked),
    .load_next  (reload_evt),
    .nx_total   (nxt_total),
    .nx_chunk   (nxt_chunk),
    .nx_linked  (nxt_linked),
    .cur_total  (cur_total),
    .cur_chunk  (cur_chunk),
    .cur_linked (cur_linked)
  );

  dma_xfer_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .step       (word_xfer),
    .chunk_size (cur_chunk),
    .total      (cur_total),
    .word_cnt   (word_count),
    .chunk_hit  (chunk_hit),
    .last_hit   (last_hit)
  );

  dma_chan_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_arm      (sw_arm),
    .sw_stop     (sw_stop),
    .err_irq_en  (cfg_err_irq_en),
    .done_irq_en (cfg_done_irq_en),
    .per_req     (per_req),
    .per_nd      (per_nd),
    .chunk_hit   (chunk_hit),
    .last_hit    (last_hit),
    .cur_linked  (cur_linked),
    .en_q        (st_enable),
    .busy_q      (st_busy),
    .done_q      (st_done),
    .err_q       (st_error),
    .irq_q       (irq),
    .ack_q       (per_ack),
    .load_q      (desc_load),
    .word_xfer   (word_xfer),
    .arm_evt     (arm_evt),
    .abort_evt   (abort_evt),
    .start_evt   (start_evt),
    .reload_evt  (reload_evt),
    .cnt_clr     (cnt_clr)
  );

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_err_irq_en,
  input logic             per_req,
  input logic             per_nd,
  input logic             per_ack,
  input logic             desc_load,
  input logic             word_xfer,
  input logic [CNT_W-1:0] word_count,
  input logic             st_enable,
  input logic             st_busy,
  input logic             st_done,
  input logic             st_error,
  input logic             irq,
  input logic             abort_evt,
  input logic             start_evt
);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !st_enable |-> !word_xfer);

  assert_idle_cnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_enable && !start_evt) |=> $stable(word_count));

  assert_abort_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!st_enable && !st_busy && st_error));

  assert_abort_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (irq == $past(cfg_err_irq_en)));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !per_nd) |=> (st_busy && !st_done && !st_error && word_count == '0));

  assert_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && per_nd) |=> (word_count == '0 && !irq));

  assert_ack_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> $past(word_xfer));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load |-> (st_busy && st_enable && word_count == '0));

  assert_stop_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> !word_xfer);

  assert_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_xfer |-> per_req);

  assert_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_busy) |-> !st_enable);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_err_irq_en (cfg_err_irq_en),
  .per_req        (per_req),
  .per_nd         (per_nd),
  .per_ack        (per_ack),
  .desc_load      (desc_load),
  .word_xfer      (word_xfer),
  .word_count     (word_count),
  .st_enable      (st_enable),
  .st_busy        (st_busy),
  .st_done        (st_done),
  .st_error       (st_error),
  .irq            (irq),
  .abort_evt      (abort_evt),
  .start_evt      (start_evt)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;

  localparam int CNT_W      = 16;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sw_arm = 1'b0, sw_stop = 1'b0;
  logic             cfg_err_irq_en = 1'b0, cfg_done_irq_en = 1'b0, cfg_linked = 1'b0;
  logic [CNT_W-1:0] cfg_total = '0, cfg_chunk = '0;
  logic             per_req = 1'b0, per_nd = 1'b0;
  logic             per_ack;
  logic [CNT_W-1:0] nxt_total = '0, nxt_chunk = '0;
  logic             nxt_linked = 1'b0;
  logic             desc_load, word_xfer;
  logic [CNT_W-1:0] word_count;
  logic             st_enable, st_busy, st_done, st_error, irq;

  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  int load_cnt = 0;
  int exp_ack[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl #(.CNT_W(CNT_W)) u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for acknowledges, counters for pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (per_ack) begin
        if (exp_ack.size() == 0) check("R5 unexpected ack, word_count", int'(word_count), -1);
        else check("R5 ack at word_count", int'(word_count), exp_ack.pop_front());
      end
      if (irq) irq_cnt++;
      if (desc_load) load_cnt++;
    end
  end

  task automatic arm(input int t, input int c, input logic lk,
                     input logic ie, input logic id);
    @(negedge clk);
    cfg_total = CNT_W'(t); cfg_chunk = CNT_W'(c); cfg_linked = lk;
    cfg_err_irq_en = ie; cfg_done_irq_en = id;
    sw_arm = 1'b1;
    @(negedge clk);
    sw_arm = 1'b0;
    @(negedge clk);   // start edge has passed
    #1;
  endtask

  // nd_mode: 0 never, 1 on last word, 2 on every word
  task automatic serve(input int n, input int nd_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      per_req = 1'b1;
      per_nd  = (nd_mode == 2) || (nd_mode == 1 && i == n - 1);
    end
    @(negedge clk);
    per_req = 1'b0;
    per_nd  = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog R1 actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("reset st_enable", st_enable, 0);
    check("reset st_busy", st_busy, 0);
    check("reset per_ack/irq", per_ack | irq, 0);

    // R1: disabled channel ignores requests
    @(negedge clk); per_req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 word_xfer while disabled", word_xfer, 0);
    check("R1 word_count while disabled", int'(word_count), 0);
    per_req = 1'b0;

    // R3, R8, R11: normal run, total 8, chunk 4, gap in requests
    exp_ack.push_back(4); exp_ack.push_back(8);
    arm(8, 4, 1'b0, 1'b0, 1'b1);
    check("R3 busy after start", st_busy, 1);
    check("R3 done cleared", st_done, 0);
    serve(3, 0);
    @(negedge clk);
    serve(5, 0);
    check("R8 word_count", int'(word_count), 8);
    check("R8 busy cleared", st_busy, 0);
    check("R8 done set", st_done, 1);
    check("R8 irq on completion", irq_cnt, 1);
    check("R11 enable cleared", st_enable, 0);

    // R4: end-of-descriptor already high at start
    irq0 = irq_cnt;
    per_nd = 1'b1;
    arm(4, 2, 1'b0, 1'b0, 1'b1);
    per_nd = 1'b0;
    check("R4 skip busy", st_busy, 0);
    check("R4 skip done", st_done, 1);
    check("R4 skip enable", st_enable, 0);
    check("R4 skip word_count", int'(word_count), 0);
    check("R4 skip no irq", irq_cnt, irq0);

    // R6: end-of-descriptor off boundary ignored, on boundary honoured
    exp_ack.push_back(4); exp_ack.push_back(8);
    arm(12, 4, 1'b0, 1'b0, 1'b1);
    serve(4, 0);
    serve(2, 2);
    check("R6 nd off boundary ignored, busy", st_busy, 1);
    check("R6 nd off boundary ignored, count", int'(word_count), 6);
    serve(2, 1);
    check("R6 peer end busy", st_busy, 0);
    check("R6 peer end done", st_done, 1);
    check("R6 peer end no irq", irq_cnt, irq0);
    check("R6 peer end word_count", int'(word_count), 8);

    // R2, R9: stop together with a request, error interrupt enabled
    arm(16, 4, 1'b0, 1'b1, 1'b0);
    serve(2, 0);
    @(negedge clk); per_req = 1'b1; sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
    @(negedge clk); per_req = 1'b0;
    #1;
    check("R9 no word in abort cycle", int'(word_count), 3);
    check("R2 error set", st_error, 1);
    check("R2 busy cleared", st_busy, 0);
    check("R2 enable cleared", st_enable, 0);
    check("R2 irq with err enable", irq_cnt, irq0 + 1);

    // R3 clears error; R2 without error interrupt; chunk of 1
    irq0 = irq_cnt;
    exp_ack.push_back(1);
    arm(2, 1, 1'b0, 1'b0, 1'b0);
    check("R3 error cleared", st_error, 0);
    check("R3 word_count zeroed", int'(word_count), 0);
    serve(1, 0);
    @(negedge clk); sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
    @(negedge clk); #1;
    check("R2 error set again", st_error, 1);
    check("R2 no irq when disabled", irq_cnt, irq0);

    // R7: chained descriptor reload coinciding with a chunk boundary
    nxt_total = 16'd6; nxt_chunk = 16'd3; nxt_linked = 1'b0;
    exp_ack.push_back(2); exp_ack.push_back(0);
    exp_ack.push_back(3); exp_ack.push_back(6);
    arm(4, 2, 1'b1, 1'b0, 1'b1);
    serve(4, 0);
    check("R7 desc_load pulses", load_cnt, 1);
    check("R7 still busy", st_busy, 1);
    check("R7 still enabled", st_enable, 1);
    check("R7 count restarted", int'(word_count), 0);
    check("R7 no done yet", st_done, 0);
    serve(6, 0);
    check("R7 second descriptor total", int'(word_count), 6);
    check("R8 chained done", st_done, 1);
    check("R8 chained irq", irq_cnt, irq0 + 1);

    repeat (2) @(negedge clk);
    check("R5 all expected acks seen", exp_ack.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule